// File: doc/BRIEF.md
# Wait-State Termination Controller

This block closes every bus cycle aimed at a chip-select region or at the default memory. When a transfer starts, it latches the timing profile of the addressed region: wait count, internal-termination enable, setup delay and hold delay. It then runs the chip-select strobe through an optional setup cycle, an access phase and an optional hold cycle. The access phase ends in one of three ways. The programmed number of wait states may run out. An external device may drive a synchronous acknowledge. An asynchronous acknowledge may arrive, and this one is resynchronized before use.

Who owns the bus changes how the synchronous acknowledge line is handled. When the internal master owns the bus, that line is an input and can end the access early. When an external master owns the bus and the region terminates internally, the block drives the line itself for the whole transfer. It asserts the line only in the final cycle and ignores the line as an input. Address decode and the data path belong to other blocks. Region index `NUM_REGIONS-1` is the default memory.

Top module: `wst_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no transfer started, `cs_o`, `done_o`, `ta_oe_o` and `ta_o` are all low.
- R2: `start_i` is taken only when no transfer is in progress. A pulse during a transfer does not change that transfer's timing and starts no further transfer.
- R3: At a taken start, the block latches the profile of region `region_i`. Region k uses bits `[k*WAIT_W +: WAIT_W]` of `wait_cfg_i` and bit k of `iterm_en_i`, `setup_en_i` and `hold_en_i`. Region `NUM_REGIONS-1` is the default memory.
- R4: With setup enabled, `cs_o` rises two cycles after the start cycle, so it stays low for one setup cycle. With setup disabled, it rises in the cycle after the start cycle.
- R5: With internal termination enabled and no early acknowledge, `done_o` is high in access cycle W+1, where W is the wait count. A count of 0 finishes in the first access cycle.
- R6: When `ta_i` acts as an input, `ta_i` high during an access cycle raises `done_o` in that same cycle.
- R7: `ata_i` passes through a two-flop synchronizer. If `ata_i` is first high in cycle n and the access is still running, `done_o` is high in cycle n+2.
- R8: With internal termination disabled, the access has no cycle limit. It ends only on `ta_i` or on the synchronized `ata_i`.
- R9: For an external-master transfer with internal termination enabled, `ta_oe_o` is high in every cycle from the cycle after the start to the last cycle of `cs_o`. In these transfers `ta_o` is high only in the `done_o` cycle, and `ta_i` has no effect.
- R10: For an external-master transfer with internal termination enabled, the synchronized `ata_i` still ends the access before the wait count runs out.
- R11: With hold enabled, `cs_o` stays high for one cycle after the `done_o` cycle. With hold disabled, it falls in the cycle after `done_o`.
- R12: `done_o` is a single-cycle pulse, once per transfer, and is high only while `cs_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer start pulse |
| ext_master_i | input | 1 | 1 when an external master owns the transfer |
| region_i | input | REGION_W | Region selected for this transfer |
| wait_cfg_i | input | NUM_REGIONS*WAIT_W | Packed wait counts, one field per region |
| iterm_en_i | input | NUM_REGIONS | Internal-termination enable per region |
| setup_en_i | input | NUM_REGIONS | Address-setup enable per region |
| hold_en_i | input | NUM_REGIONS | Address-hold enable per region |
| ta_i | input | 1 | Synchronous acknowledge, sampled as an input |
| ata_i | input | 1 | Asynchronous acknowledge |
| cs_o | output | 1 | Chip-select strobe, active high |
| done_o | output | 1 | Transfer-done pulse |
| ta_oe_o | output | 1 | Drive enable for the synchronous acknowledge line |
| ta_o | output | 1 | Value driven on the synchronous acknowledge line |

## Verification
The hardest case to reach is a race on the asynchronous acknowledge. The synchronized copy arrives two cycles late, so the stimulus has to assert `ata_i` just as an access is ending. It also has to do this while an external master owns the bus and `ta_i` is held high, so that an ignored `ta_i` can never be mistaken for the real terminator. The stimulus times `ata_i` against the start pulse of a region with a long wait count. It then repeats the race under an external master with `ta_i` held high for the whole transfer. A behavioural reference model tracks the synchronizer and the phase count, and the bench compares against it on every cycle.

// File: rtl/wst_pkg.sv
package wst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } wst_state_e;

  typedef struct packed {
    logic ext;
    logic iterm;
    logic setup;
    logic hold;
  } wst_mode_t;
endpackage

// File: rtl/wst_ata_sync.sv
module wst_ata_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wst_wait_cnt.sv
module wst_wait_cnt #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [WAIT_W-1:0] limit_i,
  output logic              expired_o
);
  localparam logic [WAIT_W-1:0] CNT_MAX = '1;

  logic [WAIT_W-1:0] cnt_q;

  // saturates so an untimed access never wraps into a false match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == limit_i);
endmodule

// File: rtl/wst_seq.sv
module wst_seq
  import wst_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  wst_mode_t         mode_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ta_i,
  input  logic              ata_s_i,
  input  logic              expired_i,
  output logic [WAIT_W-1:0] wait_o,
  output logic              cnt_clr_o,
  output logic              cnt_en_o,
  output logic              cs_o,
  output logic              done_o,
  output logic              ta_oe_o,
  output logic              ta_o,
  output logic              busy_o
);
  wst_state_e        state_q, state_d;
  wst_mode_t         mode_q;
  logic [WAIT_W-1:0] wait_q;
  logic              accept, ta_own, in_access, term;

  assign busy_o    = (state_q != ST_IDLE);
  assign accept    = start_i && !busy_o;
  assign ta_own    = mode_q.ext && mode_q.iterm;
  assign in_access = (state_q == ST_ACCESS);
  assign term      = in_access &&
                     ((mode_q.iterm && expired_i) || (!ta_own && ta_i) || ata_s_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = mode_i.setup ? ST_SETUP : ST_ACCESS;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (term) state_d = mode_q.hold ? ST_HOLD : ST_IDLE;
      ST_HOLD:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q <= mode_i;
        wait_q <= wait_i;
      end
    end
  end

  assign wait_o    = wait_q;
  assign cnt_clr_o = !in_access;
  assign cnt_en_o  = in_access && !term;
  assign cs_o      = in_access || (state_q == ST_HOLD);
  assign done_o    = term;
  assign ta_oe_o   = busy_o && ta_own;
  assign ta_o      = ta_oe_o && term;
endmodule

// File: rtl/wst_ctrl.sv
module wst_ctrl
  import wst_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned WAIT_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REGION_W   = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          ext_master_i,
  input  logic [REGION_W-1:0]           region_i,
  input  logic [NUM_REGIONS*WAIT_W-1:0] wait_cfg_i,
  input  logic [NUM_REGIONS-1:0]        iterm_en_i,
  input  logic [NUM_REGIONS-1:0]        setup_en_i,
  input  logic [NUM_REGIONS-1:0]        hold_en_i,
  input  logic                          ta_i,
  input  logic                          ata_i,
  output logic                          cs_o,
  output logic                          done_o,
  output logic                          ta_oe_o,
  output logic                          ta_o
);
  localparam logic [REGION_W-1:0] DFLT_IDX = REGION_W'(NUM_REGIONS - 1);

  logic [WAIT_W-1:0]   wait_arr [NUM_REGIONS];
  logic [REGION_W-1:0] sel_idx;
  wst_mode_t           mode_sel;
  logic [WAIT_W-1:0]   wait_sel, wait_cur;
  logic                ata_s, expired, cnt_clr, cnt_en, busy;

  generate
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_unpack
      assign wait_arr[r] = wait_cfg_i[r*WAIT_W +: WAIT_W];
    end
  endgenerate

  // unpopulated indices fall back to the default-memory profile
  assign sel_idx        = (int'(region_i) < NUM_REGIONS) ? region_i : DFLT_IDX;
  assign wait_sel       = wait_arr[sel_idx];
  assign mode_sel.ext   = ext_master_i;
  assign mode_sel.iterm = iterm_en_i[sel_idx];
  assign mode_sel.setup = setup_en_i[sel_idx];
  assign mode_sel.hold  = hold_en_i[sel_idx];

  wst_ata_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ata_i),
    .q_o   (ata_s)
  );

  wst_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .en_i     (cnt_en),
    .limit_i  (wait_cur),
    .expired_o(expired)
  );

  wst_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_sel),
    .wait_i   (wait_sel),
    .ta_i     (ta_i),
    .ata_s_i  (ata_s),
    .expired_i(expired),
    .wait_o   (wait_cur),
    .cnt_clr_o(cnt_clr),
    .cnt_en_o (cnt_en),
    .cs_o     (cs_o),
    .done_o   (done_o),
    .ta_oe_o  (ta_oe_o),
    .ta_o     (ta_o),
    .busy_o   (busy)
  );
endmodule

// File: rtl/wst_ctrl_chk.sv
module wst_ctrl_chk
  import wst_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      start_i,
  input logic      busy_i,
  input wst_mode_t mode_sel_i,
  input logic      cs_o,
  input logic      done_o,
  input logic      ta_oe_o,
  input logic      ta_o
);
  a_r4_setup_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && mode_sel_i.setup) |=> !cs_o);

  a_r4_direct_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && !mode_sel_i.setup) |=> cs_o);

  a_r9_drive_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> (ta_oe_o && done_o));

  a_r9_ta_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !ta_o);

  a_r12_done_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_o);

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!cs_o && !ta_oe_o));
endmodule

bind wst_ctrl wst_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_i    (busy),
  .mode_sel_i(mode_sel),
  .cs_o      (cs_o),
  .done_o    (done_o),
  .ta_oe_o   (ta_oe_o),
  .ta_o      (ta_o)
);

// File: tb/wst_ctrl_bench.sv
`timescale 1ns/1ps
module wst_ctrl_bench;
  localparam int NR = 8;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ext = 1'b0, ta = 1'b0, ata = 1'b0;
  logic [2:0] region = '0;
  logic [NR*WW-1:0] wait_vec;
  logic [NR-1:0] iterm_vec, setup_vec, hold_vec;
  logic cs, done, ta_oe, ta_out;

  int wcfg [NR] = '{0, 3, 6, 2, 0, 4, 15, 5};
  bit itcfg [NR] = '{1, 1, 1, 1, 0, 1, 1, 1};
  bit sucfg [NR] = '{0, 0, 1, 1, 0, 0, 0, 0};
  bit hdcfg [NR] = '{0, 0, 1, 0, 0, 1, 0, 1};

  always_comb
    for (int k = 0; k < NR; k++) begin
      wait_vec[k*WW +: WW] = WW'(wcfg[k]);
      iterm_vec[k] = itcfg[k];
      setup_vec[k] = sucfg[k];
      hold_vec[k]  = hdcfg[k];
    end

  always #2 clk = ~clk;

  wst_ctrl #(.NUM_REGIONS(NR), .WAIT_W(WW)) u_wst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ext_master_i(ext),
    .region_i(region), .wait_cfg_i(wait_vec), .iterm_en_i(iterm_vec),
    .setup_en_i(setup_vec), .hold_en_i(hold_vec), .ta_i(ta), .ata_i(ata),
    .cs_o(cs), .done_o(done), .ta_oe_o(ta_oe), .ta_o(ta_out)
  );

  // reference model: phase 0 idle, 1 setup, 2 access, 3 hold
  int phase = 0, elapsed = 0, m_wait = 0;
  bit m_ext, m_it, m_su, m_hd, sy1, sy2;
  int nvec = 0, nerr = 0, cycles = 0;
  string cur_req = "R1";

  function automatic bit m_term();
    bit own;
    own = m_ext && m_it;
    return (phase == 2) && ((m_it && elapsed == m_wait) || (!own && ta) || sy2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; elapsed = 0; sy1 = 0; sy2 = 0;
      m_ext = 0; m_it = 0; m_su = 0; m_hd = 0; m_wait = 0;
    end else begin
      bit t;
      t = m_term();
      cycles++;
      case (phase)
        0: if (start) begin
             m_ext = ext; m_it = itcfg[region]; m_su = sucfg[region];
             m_hd = hdcfg[region]; m_wait = wcfg[region]; elapsed = 0;
             phase = m_su ? 1 : 2;
           end
        1: begin phase = 2; elapsed = 0; end
        2: if (t) phase = m_hd ? 3 : 0; else elapsed++;
        default: phase = 0;
      endcase
      sy2 = sy1; sy1 = ata;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %b expected %b", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit d, oe;
    d  = m_term();
    oe = (phase != 0) && m_ext && m_it;
    chk("cs_o", cs, phase == 2 || phase == 3);
    chk("done_o", done, d);
    chk("ta_oe_o", ta_oe, oe);
    chk("ta_o", ta_out, oe && d);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(int r, bit e);
    @(posedge clk); #1;
    start = 1; region = 3'(r); ext = e;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic pulse_ta(int after);
    idle(after); ta = 1; idle(1); ta = 0;
  endtask

  task automatic pulse_ata(int after, int len);
    idle(after); ata = 1; idle(len); ata = 0;
  endtask

  initial begin
    cur_req = "R1"; idle(3); #1 rst_n = 1; idle(4);
    cur_req = "R5"; xfer(0, 0); idle(4); xfer(1, 0); idle(8);
    cur_req = "R3"; xfer(7, 0); idle(10);
    cur_req = "R4"; xfer(2, 0); idle(12); xfer(3, 0); idle(8);
    cur_req = "R11"; xfer(5, 0); idle(8);
    cur_req = "R6"; xfer(6, 0); pulse_ta(2); idle(5);
    cur_req = "R7"; xfer(6, 0); pulse_ata(1, 3); idle(8);
    xfer(6, 0); pulse_ata(13, 3); idle(8);
    cur_req = "R8"; xfer(4, 0); idle(25); pulse_ta(0); idle(3);
    xfer(4, 0); pulse_ata(10, 3); idle(8);
    xfer(4, 1); pulse_ta(3); idle(4);
    cur_req = "R9"; ta = 1; xfer(2, 1); idle(14); ta = 0; xfer(0, 1); idle(4);
    cur_req = "R10"; ta = 1; xfer(6, 1); pulse_ata(2, 3); idle(8); ta = 0;
    cur_req = "R2"; xfer(6, 0); idle(3); xfer(0, 0); idle(20);
    cur_req = "R12"; xfer(0, 0); xfer(0, 0); xfer(5, 0); xfer(5, 0); idle(10);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    nerr++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule